// File: doc/BRIEF.md
# LCD Frame Fetch Sequencer

This block is the per-frame control engine of an LCD controller. A register bank supplies its configuration: a panel enable level, a two-bit load mode, a panel-type bit (TFT), the panel width and height in pixels, a subpanel word, and two frame buffer regions. Each region is given as a top and a bottom byte address. A dual-buffer flag selects ping-pong operation, and a two-bit DMA interrupt mask is also supplied. The block does not move pixels itself. It decides, frame by frame, where a fetch engine should start reading, how long a line is and which lines to show. It also pulses the events that a status register and a DMA condition register collect.

When the enable rises, the sequencer checks every configured buffer boundary against a legal address window. Unless the load mode forbids it, it then fetches the palette header word from the start of the active buffer. On each frame-start strobe it fetches the header word again and decodes the colour depth from three bits of that word. From the depth it derives the palette header length, the pixel-data start address, the line step and the total byte count. If the frame is larger than the buffer region, the panel shuts itself off with a sync error. Otherwise the block issues a fetch pulse, marks a DMA condition bit, and in dual mode moves on to the other buffer.

The header word is obtained through a simple request/valid exchange: `hdr_req` is held high with `hdr_addr` until `hdr_valid` arrives with `hdr_word`.

Top module: `lcd_frame_seq`

## Requirements
- R1: On a rising `cfg_enable`, both boundaries of buffer 0 are checked, and both boundaries of buffer 1 as well when `dual` is 1. An address is legal when it lies in [`VALID_BASE`, `VALID_LIMIT`]. Any illegal boundary pulses `dma_cond_p` = 3'b100, pulses `dma_irq_p` when `dma_mask[1]` is 1, and leaves `panel_on` at 0. Otherwise `panel_on` becomes 1 and buffer index 0 is selected.
- R2: When the load mode is not 2, the header word is requested from the current buffer top right after a successful enable, and `pal_done_p` pulses once. Later frames re-read the header but do not pulse `pal_done_p` again until the next enable. In load mode 2 no header is requested, and the last latched header word is used.
- R3: The depth code is `hdr_word[14:12]`. Code 1 gives `pix_fmt` 1 (2 bpp), code 2 gives 2 (4 bpp) and code 3 gives 3 (8 bpp). Code 0 abandons the frame with no fetch and no other pulse.
- R4: Codes 4 to 7 are 16 bpp, with `pix_fmt` 4 (12-bit pixels) when `tft` is 0 and `pix_fmt` 5 (16-bit pixels) when `tft` is 1.
- R5: `fetch_addr` is the current buffer top plus a header offset. The offset is 0x200 for codes 3 to 7 and 0x20 for codes 1 and 2, or 0 in load mode 2.
- R6: When offset + width·height·bpp/8 exceeds (bottom − top) + 2 of the current buffer, `sync_err_p` pulses, `panel_on` drops to 0 and no fetch is issued. Equality still fetches.
- R7: A frame that passes the size check pulses `fetch_go`. It pulses `dma_cond_p` bit 0 for buffer 0 or bit 1 for buffer 1, and pulses `dma_irq_p` when `dma_mask[0]` is 1. With `dual` at 1 the next frame uses the other buffer; with `dual` at 0 it stays on buffer 0.
- R8: No fetch occurs while load mode is 1 or while the panel is off. A falling `cfg_enable` sets `buf_idle`, drops `panel_on`, and pulses `frame_done_p` unless the load mode is 1.
- R9: `line_step` equals width·bpp/8 bytes.
- R10: When `subpanel[31]` is 1 and `subpanel[29]` is 1, `first_line` = `subpanel[25:16]` and `line_cnt` = height. When bit 31 is 1 and bit 29 is 0, `first_line` = 0 and `line_cnt` = `subpanel[25:16]`. When bit 31 is 0, `first_line` = 0 and `line_cnt` = height.
- R11: After reset, `panel_on` is 0, `buf_idle` is 1 and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Panel enable level |
| load_mode | input | 2 | Load mode (1: no fetch, 2: no header read) |
| tft | input | 1 | Panel type, selects the 16 bpp pixel format |
| width | input | 11 | Pixels per line |
| height | input | 11 | Lines per frame |
| subpanel | input | 32 | Subpanel control word |
| dual | input | 1 | Alternate between the two buffers |
| b0_top | input | 32 | Buffer 0 start address |
| b0_bot | input | 32 | Buffer 0 end address |
| b1_top | input | 32 | Buffer 1 start address |
| b1_bot | input | 32 | Buffer 1 end address |
| dma_mask | input | 2 | DMA interrupt mask (bit 0 frame, bit 1 bad address) |
| frame_start | input | 1 | Frame start strobe |
| hdr_valid | input | 1 | Header word valid |
| hdr_word | input | 16 | First palette word of the buffer |
| hdr_req | output | 1 | Header word request |
| hdr_addr | output | 32 | Header word address |
| panel_on | output | 1 | Panel running |
| buf_idle | output | 1 | Buffer index idle |
| buf_idx | output | 1 | Current buffer index |
| fetch_go | output | 1 | Fetch start pulse |
| fetch_addr | output | 32 | Pixel data start address |
| line_step | output | 12 | Bytes per line |
| pix_fmt | output | 3 | Pixel format code |
| first_line | output | 10 | First displayed line |
| line_cnt | output | 11 | Number of displayed lines |
| pal_done_p | output | 1 | Palette loaded pulse |
| frame_done_p | output | 1 | Frame done pulse on disable |
| sync_err_p | output | 1 | Sync error pulse |
| dma_cond_p | output | 3 | DMA condition bit pulses |
| dma_irq_p | output | 1 | DMA interrupt pulse |

## Verification
The properties assume that `frame_start` is a single-cycle strobe, and that `hdr_valid` is only raised while `hdr_req` is high. The bench's header responder answers one half cycle after each request, and frame strobes are spaced well beyond the five cycles a frame takes. Configuration inputs are assumed stable while a frame is in flight. The stimulus changes buffer bounds, depth headers, `tft` and the subpanel word only between frames, and changes `load_mode` only while the enable is low.

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
  parameter int AW = 32,
  parameter int DW = 11,
  parameter int LW = 10,
  parameter logic [AW-1:0] VALID_BASE  = 32'h1000_0000,
  parameter logic [AW-1:0] VALID_LIMIT = 32'h1FFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [1:0]    load_mode,
  input  logic          tft,
  input  logic [DW-1:0] width,
  input  logic [DW-1:0] height,
  input  logic [31:0]   subpanel,
  input  logic          dual,
  input  logic [AW-1:0] b0_top,
  input  logic [AW-1:0] b0_bot,
  input  logic [AW-1:0] b1_top,
  input  logic [AW-1:0] b1_bot,
  input  logic [1:0]    dma_mask,
  input  logic          frame_start,
  input  logic          hdr_valid,
  input  logic [15:0]   hdr_word,
  output logic          hdr_req,
  output logic [AW-1:0] hdr_addr,
  output logic          panel_on,
  output logic          buf_idle,
  output logic          buf_idx,
  output logic          fetch_go,
  output logic [AW-1:0] fetch_addr,
  output logic [DW:0]   line_step,
  output logic [2:0]    pix_fmt,
  output logic [LW-1:0] first_line,
  output logic [DW-1:0] line_cnt,
  output logic          pal_done_p,
  output logic          frame_done_p,
  output logic          sync_err_p,
  output logic [2:0]    dma_cond_p,
  output logic          dma_irq_p
);
  localparam int NW = 2*DW + 2;
  localparam int RW = AW + 2;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_PAL, S_DECODE, S_SIZE} state_t;
  state_t state;

  logic          en_q, pal_loaded, in_frame;
  logic [2:0]    code;
  logic [NW-1:0] need;
  logic [AW-1:0] off_r;
  logic [DW:0]   step_r;
  logic [2:0]    fmt_r;

  logic en_rise, en_fall;
  assign en_rise = cfg_enable & ~en_q;
  assign en_fall = ~cfg_enable & en_q;

  function automatic logic in_win(input logic [AW-1:0] a);
    return (a >= VALID_BASE) && (a <= VALID_LIMIT);
  endfunction

  logic addr_good;
  assign addr_good = in_win(b0_top) && in_win(b0_bot) &&
                     (!dual || (in_win(b1_top) && in_win(b1_bot)));

  logic [AW-1:0] cur_top, cur_bot;
  assign cur_top  = buf_idx ? b1_top : b0_top;
  assign cur_bot  = buf_idx ? b1_bot : b0_bot;
  assign hdr_req  = (state == S_PAL);
  assign hdr_addr = cur_top;

  logic [2*DW-1:0] pix;
  assign pix = {{DW{1'b0}}, width} * {{DW{1'b0}}, height};

  logic [NW-1:0] bytes_c, off_c;
  logic [DW:0]   step_c;
  logic [2:0]    fmt_c;
  always_comb begin
    case (code)
      3'd1:    begin bytes_c = {2'b00, pix} >> 2; step_c = {1'b0, width} >> 2; fmt_c = 3'd1; end
      3'd2:    begin bytes_c = {2'b00, pix} >> 1; step_c = {1'b0, width} >> 1; fmt_c = 3'd2; end
      3'd3:    begin bytes_c = {2'b00, pix};      step_c = {1'b0, width};      fmt_c = 3'd3; end
      default: begin bytes_c = {1'b0, pix, 1'b0}; step_c = {width, 1'b0};      fmt_c = tft ? 3'd5 : 3'd4; end
    endcase
    if (load_mode == 2'd2)  off_c = '0;
    else if (code >= 3'd3)  off_c = NW'(12'h200);
    else                    off_c = NW'(12'h020);
  end

  logic signed [RW-1:0] room_c, need_x;
  assign room_c = $signed({2'b00, cur_bot} - {2'b00, cur_top} + RW'(2));
  assign need_x = $signed({{(RW-NW){1'b0}}, need});

  logic [LW-1:0] sp_lines;
  logic          sp_on, sp_first;
  assign sp_lines = subpanel[16 +: LW];
  assign sp_on    = subpanel[31];
  assign sp_first = subpanel[29];

  logic unused_bits;
  assign unused_bits = ^{hdr_word[15], hdr_word[11:0], subpanel[30], subpanel[28:16+LW], subpanel[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      en_q <= 1'b0;
      panel_on <= 1'b0;
      buf_idle <= 1'b1;
      buf_idx <= 1'b0;
      pal_loaded <= 1'b0;
      in_frame <= 1'b0;
      code <= '0;
      need <= '0;
      off_r <= '0;
      step_r <= '0;
      fmt_r <= '0;
      fetch_go <= 1'b0;
      fetch_addr <= '0;
      line_step <= '0;
      pix_fmt <= '0;
      first_line <= '0;
      line_cnt <= '0;
      pal_done_p <= 1'b0;
      frame_done_p <= 1'b0;
      sync_err_p <= 1'b0;
      dma_cond_p <= '0;
      dma_irq_p <= 1'b0;
    end else begin
      en_q <= cfg_enable;
      fetch_go <= 1'b0;
      pal_done_p <= 1'b0;
      frame_done_p <= 1'b0;
      sync_err_p <= 1'b0;
      dma_cond_p <= '0;
      dma_irq_p <= 1'b0;
      if (en_fall) begin
        panel_on <= 1'b0;
        buf_idle <= 1'b1;
        buf_idx <= 1'b0;
        in_frame <= 1'b0;
        frame_done_p <= (load_mode != 2'd1);
        state <= S_IDLE;
      end else if (en_rise) begin
        state <= S_CHECK;
      end else begin
        case (state)
          S_IDLE:
            if (panel_on && frame_start && load_mode != 2'd1) begin
              in_frame <= 1'b1;
              state <= (load_mode == 2'd2) ? S_DECODE : S_PAL;
            end
          S_CHECK:
            if (!addr_good) begin
              dma_cond_p <= 3'b100;
              dma_irq_p <= dma_mask[1];
              state <= S_IDLE;
            end else begin
              panel_on <= 1'b1;
              buf_idle <= 1'b0;
              buf_idx <= 1'b0;
              pal_loaded <= 1'b0;
              in_frame <= 1'b0;
              state <= (load_mode == 2'd2) ? S_IDLE : S_PAL;
            end
          S_PAL:
            if (hdr_valid) begin
              code <= hdr_word[14:12];
              if (!pal_loaded) begin
                pal_done_p <= 1'b1;
                pal_loaded <= 1'b1;
              end
              state <= in_frame ? S_DECODE : S_IDLE;
            end
          S_DECODE:
            if (code == 3'd0) begin
              in_frame <= 1'b0;
              state <= S_IDLE;
            end else begin
              need <= bytes_c + off_c;
              off_r <= AW'(off_c);
              step_r <= step_c;
              fmt_r <= fmt_c;
              state <= S_SIZE;
            end
          S_SIZE: begin
            in_frame <= 1'b0;
            state <= S_IDLE;
            if (need_x > room_c) begin
              sync_err_p <= 1'b1;
              panel_on <= 1'b0;
            end else begin
              fetch_go <= 1'b1;
              fetch_addr <= cur_top + off_r;
              line_step <= step_r;
              pix_fmt <= fmt_r;
              first_line <= (sp_on && sp_first) ? sp_lines : '0;
              line_cnt <= (sp_on && !sp_first) ? DW'(sp_lines) : height;
              dma_cond_p <= buf_idx ? 3'b010 : 3'b001;
              dma_irq_p <= dma_mask[0];
              if (dual) buf_idx <= ~buf_idx;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_enable,
  input logic       fetch_go,
  input logic       sync_err_p,
  input logic       panel_on,
  input logic       frame_done_p,
  input logic       buf_idle,
  input logic [2:0] dma_cond_p
);
  // R6
  sync_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_p |-> !panel_on);

  // R7
  cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_cond_p));

  // R7
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go);

  // R8
  fetch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> $past(cfg_enable));

  // R8
  idle_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_idle |-> !fetch_go);

  // R8
  disable_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_p |-> (!panel_on && buf_idle));
endmodule

bind lcd_frame_seq lcd_frame_seq_chk chk_i (.*);

// File: tb/lcd_frame_seq_tb.sv
`timescale 1ns/1ps
module lcd_frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  load_mode = 2'd0;
  logic        tft = 1'b0;
  logic [10:0] width = 11'd64;
  logic [10:0] height = 11'd32;
  logic [31:0] subpanel = 32'h0;
  logic        dual = 1'b0;
  logic [31:0] b0_top = 32'h1000_0000, b0_bot = 32'h1001_0000;
  logic [31:0] b1_top = 32'h1100_0000, b1_bot = 32'h1101_0000;
  logic [1:0]  dma_mask = 2'b00;
  logic        frame_start = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [15:0] hdr_word = 16'h0;
  logic        hdr_req;
  logic [31:0] hdr_addr;
  logic        panel_on, buf_idle, buf_idx, fetch_go;
  logic [31:0] fetch_addr;
  logic [11:0] line_step;
  logic [2:0]  pix_fmt;
  logic [9:0]  first_line;
  logic [10:0] line_cnt;
  logic        pal_done_p, frame_done_p, sync_err_p, dma_irq_p;
  logic [2:0]  dma_cond_p;

  logic [15:0] hdr0 = 16'h3000, hdr1 = 16'h1000;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  int n_fetch, n_pal, n_sync, n_fdone, n_irq, n_c0, n_c1, n_c2;
  logic [31:0] l_addr;
  logic [11:0] l_step;
  logic [2:0]  l_fmt;
  logic [9:0]  l_first;
  logic [10:0] l_cnt;

  always #2.5 clk = ~clk;

  lcd_frame_seq dut_i (.*);

  always @(negedge clk) begin
    hdr_valid <= hdr_req;
    hdr_word  <= (hdr_addr == b1_top) ? hdr1 : hdr0;
    if (fetch_go) begin
      n_fetch++; l_addr = fetch_addr; l_step = line_step; l_fmt = pix_fmt;
      l_first = first_line; l_cnt = line_cnt;
    end
    if (pal_done_p) n_pal++;
    if (sync_err_p) n_sync++;
    if (frame_done_p) n_fdone++;
    if (dma_irq_p) n_irq++;
    if (dma_cond_p[0]) n_c0++;
    if (dma_cond_p[1]) n_c1++;
    if (dma_cond_p[2]) n_c2++;
  end

  task automatic clr();
    n_fetch = 0; n_pal = 0; n_sync = 0; n_fdone = 0; n_irq = 0;
    n_c0 = 0; n_c1 = 0; n_c2 = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable();
    @(negedge clk); cfg_enable = 1'b1; wait_cyc(8);
  endtask

  task automatic disable_p();
    @(negedge clk); cfg_enable = 1'b0; wait_cyc(4);
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_reset();
    chk("R11 panel_on", panel_on, 0);
    chk("R11 buf_idle", buf_idle, 1);
    chk("R11 pulses", {fetch_go, pal_done_p, sync_err_p, frame_done_p, dma_irq_p, dma_cond_p}, 0);
  endtask

  task automatic t_bad_addr();
    clr(); dma_mask = 2'b10; b0_top = 32'h0800_0000;
    enable();
    chk("R1 cond bit2", n_c2, 1);
    chk("R1 irq", n_irq, 1);
    chk("R1 panel off", panel_on, 0);
    chk("R1 no palette", n_pal, 0);
    disable_p();
    b0_top = 32'h1000_0000; b1_bot = 32'h2000_0000; dual = 1'b1; clr();
    enable();
    chk("R1 dual bad buf1", n_c2, 1);
    chk("R1 dual panel off", panel_on, 0);
    disable_p();
    dual = 1'b0; clr();
    enable();
    chk("R1 single ignores buf1", panel_on, 1);
    chk("R1 single no cond", n_c2, 0);
    disable_p();
    b1_bot = 32'h1101_0000;
  endtask

  task automatic t_basic();
    dual = 1'b1; dma_mask = 2'b01; hdr0 = 16'h3000; hdr1 = 16'h1000; clr();
    enable();
    chk("R2 palette pulse", n_pal, 1);
    chk("R1 panel on", panel_on, 1);
    frame();
    chk("R5 addr code3", l_addr, 32'h1000_0200);
    chk("R9 step 8bpp", l_step, 64);
    chk("R3 fmt code3", l_fmt, 3);
    chk("R7 cond0", n_c0, 1);
    chk("R7 irq", n_irq, 1);
    chk("R2 once per enable", n_pal, 1);
    frame();
    chk("R7 toggled addr", l_addr, 32'h1100_0020);
    chk("R9 step 2bpp", l_step, 16);
    chk("R3 fmt code1", l_fmt, 1);
    chk("R7 cond1", n_c1, 1);
    hdr0 = 16'h2000;
    frame();
    chk("R7 back to buf0", l_addr, 32'h1000_0020);
    chk("R3 fmt code2", l_fmt, 2);
    chk("R9 step 4bpp", l_step, 32);
    chk("R7 fetch count", n_fetch, 3);
    disable_p();
    chk("R8 frame done", n_fdone, 1);
    chk("R8 idle", buf_idle, 1);
    chk("R8 off", panel_on, 0);
  endtask

  task automatic t_tft();
    dual = 1'b0; dma_mask = 2'b00; hdr0 = 16'h5000; tft = 1'b0; clr();
    enable(); frame();
    chk("R4 fmt 12bit", l_fmt, 4);
    chk("R9 step 16bpp", l_step, 128);
    chk("R5 addr code5", l_addr, 32'h1000_0200);
    tft = 1'b1; frame();
    chk("R4 fmt 16bit", l_fmt, 5);
    chk("R7 single stays buf0", l_addr, 32'h1000_0200);
    chk("R7 masked irq", n_irq, 0);
    disable_p(); tft = 1'b0;
  endtask

  task automatic t_code0();
    hdr0 = 16'h8FFF; clr();
    enable(); frame();
    chk("R3 code0 no fetch", n_fetch, 0);
    chk("R3 code0 no cond", n_c0, 0);
    chk("R3 code0 panel stays", panel_on, 1);
    disable_p();
  endtask

  task automatic t_size();
    hdr0 = 16'h3000; b0_bot = 32'h1000_0000 + 32'd2558; clr();
    enable(); frame();
    chk("R6 exact fit fetches", n_fetch, 1);
    chk("R6 exact fit no err", n_sync, 0);
    b0_bot = 32'h1000_0000 + 32'd2557; clr();
    frame();
    chk("R6 overflow err", n_sync, 1);
    chk("R6 panel off", panel_on, 0);
    chk("R6 no fetch", n_fetch, 0);
    frame();
    chk("R8 off no fetch", n_fetch, 0);
    disable_p();
    b0_bot = 32'h1001_0000;
  endtask

  task automatic t_mode2();
    load_mode = 2'd2; clr();
    enable();
    chk("R2 mode2 no palette", n_pal, 0);
    frame();
    chk("R5 mode2 offset 0", l_addr, 32'h1000_0000);
    chk("R2 mode2 stale code", l_fmt, 3);
    disable_p();
  endtask

  task automatic t_mode1();
    load_mode = 2'd1; clr();
    enable(); frame();
    chk("R8 mode1 no fetch", n_fetch, 0);
    disable_p();
    chk("R8 mode1 no frame done", n_fdone, 0);
    load_mode = 2'd0;
  endtask

  task automatic t_subpanel();
    hdr0 = 16'h3000; subpanel = 32'hA005_0000; clr();
    enable(); frame();
    chk("R10 first line", l_first, 5);
    chk("R10 full count", l_cnt, 32);
    subpanel = 32'h8007_0000; frame();
    chk("R10 short first", l_first, 0);
    chk("R10 short count", l_cnt, 7);
    subpanel = 32'h2009_0000; frame();
    chk("R10 off first", l_first, 0);
    chk("R10 off count", l_cnt, 32);
    disable_p();
  endtask

  initial begin
    clr();
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_bad_addr();
    t_basic();
    t_tft();
    t_code0();
    t_size();
    t_mode2();
    t_mode1();
    t_subpanel();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule